// File: doc/BRIEF.md
# Programmable Interrupt Selector and Prioritizer

This block sits between a set of up to 32 peripheral event wires and a CPU that has 16 interrupt lines. Lines 0 to 3 come from four dedicated event pins, which are reset, non-maskable interrupt and two reserved lines. They cannot be remapped and they ignore every mask. Each of lines 4 to 15 has its own 5-bit source selector, which picks one of the 32 event inputs. Two selector registers hold these fields, and a small word-addressed register bus writes and reads them.

A rising edge on a line's source sets a sticky pending flag for that line. An acknowledge that names the line clears the flag. A per-line enable register and a global enable gate the maskable lines. A registered encoder then reports whether any line is pending and enabled, together with the lowest such line number.

The event, acknowledge and interrupt pins are plain control signals. Events and acknowledges are sampled on every clock. The interrupt output is a level that stays up while the condition holds, so no pin applies back-pressure.

Top module: `irq_selector`

## Requirements
- R1: After reset the output reports no interrupt, the global enable reads 0, and the selectors of lines 4..15 hold, in line order, the codes 4, 5, 6, 7, 8, 9, 3, 10, 11, 0, 1, 2.
- R2: Register word 0 holds the selectors of lines 10..15 and word 1 holds those of lines 4..9. In each word the k-th line (k = 0..5) uses bits [5k+4:5k] for k<3 and bits [5k+5:5k+1] for k>=3. Bits 15 and 31 read 0. A selector value routes event input number `value` to its line.
- R3: A rising edge on a line's selected source sets its pending flag. An event held high sets it only once, so after an acknowledge the line stays idle until a new rising edge.
- R4: Lines 0..3 take rising edges of `fixed_evt[3:0]` and are reported regardless of the enable register and the global enable.
- R5: A line from 4 to 15 is reported only while its bit in enable word 2 (bits [15:4]) is 1 and the global enable (word 3, bit 0) is 1. A pending flag that is masked is kept, not dropped.
- R6: When several lines are pending and enabled, the lowest line number is reported.
- R7: `ack_valid` with `ack_num` = n clears line n's pending flag. Any line can be acknowledged, including lines 0..3.
- R8: Selector codes 24..29 are reserved. A line routed to such a code never becomes pending. Codes 30 and 31 are ordinary sources.
- R9: If an acknowledge of line n and a new rising edge on line n's source fall in the same cycle, the line stays pending.
- R10: Rewriting a line's selector while that line is pending keeps the pending flag until the line is acknowledged.
- R11: Bits [3:0] of enable word 2 always read 1, whatever value is written.
- R12: `irq_valid` and `irq_num` are registered. They change on the clock edge after the pending flags or masks change, which is two edges after an event is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index (0 high selectors, 1 low selectors, 2 enable, 3 global enable) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| evt_in | input | 32 | Peripheral event inputs |
| fixed_evt | input | 4 | Event pins of the fixed lines 0..3 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Line number being acknowledged |
| irq_valid | output | 1 | Some enabled line is pending |
| irq_num | output | 4 | Lowest pending enabled line number |

## Verification
Two functions can act on the same pending flag in one clock: clearing it through an acknowledge and setting it through a fresh rising edge on the line's selected source. The bench provokes this by first leaving a line pending with its source back low. In a single cycle it then drives the acknowledge of that line and raises the source. It judges the result by checking that the line is still reported two edges later, and that it disappears only after a second, lone acknowledge. Selector rewrites on a pending line are judged the same way, by watching the reported number across the rewrite.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int LINES   = 16;
  localparam int FIXED   = 4;
  localparam int EVENTS  = 32;
  localparam int SEL_W   = $clog2(EVENTS);
  localparam int MASKED  = LINES - FIXED;
  localparam int NUM_W   = $clog2(LINES);
  localparam int WORD_W  = 32;

  // bit offset of the k-th selector field inside a selector word
  function automatic int field_lsb(input int k);
    return k * SEL_W + ((k >= 3) ? 1 : 0);
  endfunction

  // power-up source code of maskable line (m + FIXED)
  function automatic logic [SEL_W-1:0] boot_sel(input int m);
    case (m)
      0: return SEL_W'(4);
      1: return SEL_W'(5);
      2: return SEL_W'(6);
      3: return SEL_W'(7);
      4: return SEL_W'(8);
      5: return SEL_W'(9);
      6: return SEL_W'(3);
      7: return SEL_W'(10);
      8: return SEL_W'(11);
      9: return SEL_W'(0);
      10: return SEL_W'(1);
      default: return SEL_W'(2);
    endcase
  endfunction

  function automatic logic code_reserved(input logic [SEL_W-1:0] c);
    return (c >= SEL_W'(24)) && (c <= SEL_W'(29));
  endfunction
endpackage

// File: rtl/irqsel_regs.sv
module irqsel_regs
  import irqsel_pkg::*;
#(
  parameter int NSEL   = MASKED,
  parameter int SW     = SEL_W,
  parameter int NLINES = LINES,
  parameter int NFIX   = FIXED,
  parameter int DW     = WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [1:0]                addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic [NSEL-1:0][SW-1:0]   sel,
  output logic [NLINES-NFIX-1:0]    en,
  output logic                      gie
);
  localparam int PER_WORD = NSEL / 2;

  logic [NSEL-1:0][SW-1:0]  sel_q;
  logic [NLINES-NFIX-1:0]   en_q;
  logic                     gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NSEL; m++) sel_q[m] <= boot_sel(m);
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (we) begin
      case (addr)
        2'd0: for (int k = 0; k < PER_WORD; k++)
                sel_q[PER_WORD + k] <= wdata[field_lsb(k) +: SW];
        2'd1: for (int k = 0; k < PER_WORD; k++)
                sel_q[k] <= wdata[field_lsb(k) +: SW];
        2'd2: en_q  <= wdata[NLINES-1:NFIX];
        default: gie_q <= wdata[0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: for (int k = 0; k < PER_WORD; k++)
              rdata[field_lsb(k) +: SW] = sel_q[PER_WORD + k];
      2'd1: for (int k = 0; k < PER_WORD; k++)
              rdata[field_lsb(k) +: SW] = sel_q[k];
      2'd2: rdata[NLINES-1:0] = {en_q, {NFIX{1'b1}}};
      default: rdata[0] = gie_q;
    endcase
  end

  assign sel = sel_q;
  assign en  = en_q;
  assign gie = gie_q;
endmodule

// File: rtl/irqsel_capture.sv
module irqsel_capture
  import irqsel_pkg::*;
#(
  parameter int NEVT   = EVENTS,
  parameter int SW     = SEL_W,
  parameter int NLINES = LINES,
  parameter int NFIX   = FIXED,
  parameter int NW     = NUM_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NEVT-1:0]                   evt_in,
  input  logic [NFIX-1:0]                   fixed_evt,
  input  logic [NLINES-NFIX-1:0][SW-1:0]    sel,
  input  logic                              ack_valid,
  input  logic [NW-1:0]                     ack_num,
  output logic [NLINES-1:0]                 pend
);
  logic [NEVT-1:0]   evt_q;
  logic [NFIX-1:0]   fix_q;
  logic [NEVT-1:0]   evt_rise;
  logic [NFIX-1:0]   fix_rise;
  logic [NLINES-1:0] hit;
  logic [NLINES-1:0] clr;
  logic [NLINES-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      fix_q <= '0;
    end else begin
      evt_q <= evt_in;
      fix_q <= fixed_evt;
    end
  end

  assign evt_rise = evt_in & ~evt_q;
  assign fix_rise = fixed_evt & ~fix_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    if (g < NFIX) begin : g_fixed
      assign hit[g] = fix_rise[g];
    end else begin : g_routed
      assign hit[g] = evt_rise[sel[g-NFIX]] && !code_reserved(sel[g-NFIX]);
    end
    assign clr[g] = ack_valid && (ack_num == NW'(g));
    // a new edge wins over a clearing acknowledge in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= hit[g] | (pend_q[g] & ~clr[g]);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irqsel_prio.sv
module irqsel_prio
  import irqsel_pkg::*;
#(
  parameter int NLINES = LINES,
  parameter int NFIX   = FIXED,
  parameter int NW     = NUM_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLINES-1:0]      pend,
  input  logic [NLINES-NFIX-1:0] en,
  input  logic                   gie,
  output logic                   irq_valid,
  output logic [NW-1:0]          irq_num
);
  logic [NLINES-1:0] allow;
  logic [NLINES-1:0] live;
  logic [NW-1:0]     first;

  assign allow = {en & {(NLINES-NFIX){gie}}, {NFIX{1'b1}}};
  assign live  = pend & allow;

  always_comb begin
    first = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (live[i]) first = NW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_num   <= '0;
    end else begin
      irq_valid <= |live;
      irq_num   <= first;
    end
  end
endmodule

// File: rtl/irq_selector.sv
module irq_selector
  import irqsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [EVENTS-1:0] evt_in,
  input  logic [FIXED-1:0]  fixed_evt,
  input  logic              ack_valid,
  input  logic [NUM_W-1:0]  ack_num,
  output logic              irq_valid,
  output logic [NUM_W-1:0]  irq_num
);
  logic [MASKED-1:0][SEL_W-1:0] sel_w;
  logic [MASKED-1:0]            en_w;
  logic                         gie_w;
  logic [LINES-1:0]             pend_w;

  irqsel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .sel(sel_w), .en(en_w), .gie(gie_w)
  );

  irqsel_capture u_cap (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .fixed_evt(fixed_evt),
    .sel(sel_w), .ack_valid(ack_valid), .ack_num(ack_num), .pend(pend_w)
  );

  irqsel_prio u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend_w), .en(en_w), .gie(gie_w),
    .irq_valid(irq_valid), .irq_num(irq_num)
  );
endmodule

// File: rtl/irq_selector_chk.sv
module irq_selector_chk
  import irqsel_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic [LINES-1:0]             pend,
  input logic [MASKED-1:0][SEL_W-1:0] sel,
  input logic                         gie,
  input logic                         ack_valid,
  input logic [NUM_W-1:0]             ack_num,
  input logic                         irq_valid,
  input logic [NUM_W-1:0]             irq_num,
  input logic [1:0]                   bus_addr,
  input logic [WORD_W-1:0]            bus_rdata
);
  logic [LINES-1:0] pend_d;
  logic             gie_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d <= '0;
      gie_d  <= 1'b0;
    end else begin
      pend_d <= pend;
      gie_d  <= gie;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // R10 / R3: pending is sticky unless its own acknowledge arrives
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !(ack_valid && ack_num == NUM_W'(g))) |=> pend[g]);
    // R7: a pending flag only drops after an acknowledge naming it
    a_r7_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[g]) |-> $past(ack_valid && ack_num == NUM_W'(g)));
    if (g >= FIXED) begin : g_rsv
      // R8: reserved source codes never raise a line
      a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[g]) |-> !code_reserved($past(sel[g-FIXED])));
    end
  end

  // R6 / R12: the reported line was pending one cycle earlier
  a_r6_reported_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend_d[irq_num]);
  // R4: a pending fixed line always forces a fixed-line report
  a_r4_fixed_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_d[FIXED-1:0] != '0) |-> (irq_valid && irq_num < NUM_W'(FIXED)));
  // R5: maskable lines need the global enable
  a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_num >= NUM_W'(FIXED)) |-> gie_d);
  // R2: gap bits of the selector words read zero
  a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 2'd2) |-> (bus_rdata[15] == 1'b0 && bus_rdata[31] == 1'b0));
  // R11: fixed enable bits read one
  a_r11_fixed_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[3:0] == 4'hF));
endmodule

bind irq_selector irq_selector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_w), .sel(sel_w), .gie(gie_w),
  .ack_valid(ack_valid), .ack_num(ack_num), .irq_valid(irq_valid),
  .irq_num(irq_num), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/irq_selector_test.sv
module irq_selector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in = '0;
  logic [3:0]  fixed_evt = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic        irq_valid;
  logic [3:0]  irq_num;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {bit v; bit [3:0] n; string tag;} exp_t;
  exp_t exp_q[$];

  int sel_lo[6] = '{4, 5, 6, 7, 8, 9};
  int sel_hi[6] = '{3, 10, 11, 0, 1, 2};

  always #4 clk = ~clk;

  irq_selector uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .fixed_evt(fixed_evt), .ack_valid(ack_valid), .ack_num(ack_num),
    .irq_valid(irq_valid), .irq_num(irq_num)
  );

  // monitor: compare the oldest expectation away from the edge
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (irq_valid !== e.v || (e.v && irq_num !== e.n)) begin
        failures++;
        $display("FAIL %s: irq valid=%0d num=%0d, expected valid=%0d num=%0d",
                 e.tag, irq_valid, irq_num, e.v, e.n);
      end
    end
  end

  function automatic logic [31:0] pack(input int f[6]);
    logic [31:0] w = '0;
    for (int k = 0; k < 6; k++) w[k*5 + ((k >= 3) ? 1 : 0) +: 5] = 5'(f[k]);
    return w;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input bit v, input int n, input string tag);
    step(2);
    exp_q.push_back('{v, 4'(n), tag});
    step(1);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 2'(a); bus_wdata = d; bus_we = 1'b1;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    bus_addr = 2'(a);
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s: word %0d read %h, expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic pulse_evt(input int i);
    evt_in[i] = 1'b1; step(1); evt_in[i] = 1'b0;
  endtask

  task automatic pulse_fix(input int i);
    fixed_evt[i] = 1'b1; step(1); fixed_evt[i] = 1'b0;
  endtask

  task automatic ack(input int n);
    ack_valid = 1'b1; ack_num = 4'(n); step(1); ack_valid = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    exp_q.push_back('{1'b0, 4'd0, "R1 reset output"});
    step(1);
    rd_check(0, pack(sel_hi), "R1 R2 high selector defaults");
    rd_check(1, pack(sel_lo), "R1 R2 low selector defaults");
    rd_check(3, 32'h0, "R1 global enable off");
    rd_check(2, 32'h0000_000F, "R11 enable reset");
    wr(2, 32'h0);
    rd_check(2, 32'h0000_000F, "R11 fixed bits stay one");

    // R4 fixed line ignores masks
    pulse_fix(1);
    expect_irq(1'b1, 1, "R4 fixed line with masks off");
    ack(1);
    expect_irq(1'b0, 0, "R7 ack clears fixed line");

    // R5 masking, pending kept
    pulse_evt(4);
    expect_irq(1'b0, 0, "R5 masked line hidden");
    wr(2, 32'h0000_0010);
    expect_irq(1'b0, 0, "R5 global enable still off");
    wr(3, 32'h1);
    expect_irq(1'b1, 4, "R5 R3 unmasked pending line");
    ack(4);
    expect_irq(1'b0, 0, "R7 ack line 4");

    // R6 priority
    wr(2, 32'h0000_FFFF);
    evt_in[0] = 1'b1; evt_in[3] = 1'b1; step(1); evt_in[0] = 1'b0; evt_in[3] = 1'b0;
    expect_irq(1'b1, 10, "R6 line 10 over 13");
    pulse_fix(2);
    expect_irq(1'b1, 2, "R6 fixed line wins");
    ack(2);
    expect_irq(1'b1, 10, "R6 back to 10");
    ack(10);
    expect_irq(1'b1, 13, "R6 then 13");
    ack(13);
    expect_irq(1'b0, 0, "R7 all cleared");

    // R3 level held triggers once
    evt_in[5] = 1'b1;
    expect_irq(1'b1, 5, "R3 edge of held event");
    ack(5);
    expect_irq(1'b0, 0, "R3 no retrigger while held");
    evt_in[5] = 1'b0;
    step(1);

    // R8 reserved codes
    sel_lo[0] = 24; wr(1, pack(sel_lo));
    pulse_evt(24);
    expect_irq(1'b0, 0, "R8 code 24 reserved");
    sel_lo[0] = 29; wr(1, pack(sel_lo));
    pulse_evt(29);
    expect_irq(1'b0, 0, "R8 code 29 reserved");
    sel_lo[0] = 30; wr(1, pack(sel_lo));
    pulse_evt(30);
    expect_irq(1'b1, 4, "R8 code 30 usable");
    ack(4);
    sel_lo[0] = 31; wr(1, pack(sel_lo));
    pulse_evt(31);
    expect_irq(1'b1, 4, "R8 code 31 usable");
    ack(4);
    expect_irq(1'b0, 0, "R7 clear line 4");

    // R2 field layout: line 9 uses bits [30:26]
    wr(1, 32'hFFFF_FFFF);
    rd_check(1, 32'h7FFF_7FFF, "R2 gap bits read zero");
    sel_lo = '{4, 5, 6, 7, 8, 17};
    wr(1, pack(sel_lo));
    rd_check(1, pack(sel_lo), "R2 low word readback");
    pulse_evt(17);
    expect_irq(1'b1, 9, "R2 line 9 routed to event 17");
    ack(9);
    sel_hi = '{3, 10, 11, 0, 1, 21};
    wr(0, pack(sel_hi));
    pulse_evt(21);
    expect_irq(1'b1, 15, "R2 line 15 routed to event 21");
    ack(15);

    // R10 selector rewrite keeps pending
    pulse_evt(6);
    expect_irq(1'b1, 6, "R10 line 6 pending");
    sel_lo[2] = 7; wr(1, pack(sel_lo));
    expect_irq(1'b1, 6, "R10 kept after rewrite");
    ack(6);
    expect_irq(1'b0, 0, "R10 cleared by ack");

    // R9 ack and new edge in the same cycle (line 7, source 7)
    pulse_evt(7);
    expect_irq(1'b1, 6, "R9 setup, line 6 now on source 7");
    ack(6);
    step(1);
    // line 7 remains pending from the same pulse
    ack_valid = 1'b1; ack_num = 4'd7; evt_in[7] = 1'b1;
    step(1);
    ack_valid = 1'b0; evt_in[7] = 1'b0;
    // edge also re-pends line 6 (source 7); acknowledge it alone
    ack(6);
    expect_irq(1'b1, 7, "R9 set wins over clear");
    ack(7);
    expect_irq(1'b0, 0, "R9 lone ack clears");

    // R12 timing: one edge after the pending flag is too early
    evt_in[8] = 1'b1;
    step(1);
    exp_q.push_back('{1'b0, 4'd0, "R12 not yet after one edge"});
    step(1);
    exp_q.push_back('{1'b1, 4'd8, "R12 visible after two edges"});
    step(1);
    evt_in[8] = 1'b0;
    wr(3, 32'h0);
    expect_irq(1'b0, 0, "R5 global enable off hides line 8");
    pulse_fix(0);
    expect_irq(1'b1, 0, "R4 line 0 with global off");
    ack(0);
    wr(3, 32'h1);
    expect_irq(1'b1, 8, "R5 line 8 kept while masked");
    ack(8);
    expect_irq(1'b0, 0, "R7 final clear");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule